// File: doc/BRIEF.md
# DDR2 Self-Refresh Sequencer

This block sits between a memory controller's command scheduler and the DDR2 command pins. It puts the device into self-refresh and brings it back out. On an entry request it waits until every bank is idle and no refresh is owed. It then holds on-die termination off for a programmed lead time and issues the self-refresh entry command with the clock-enable pin dropped in the same cycle. While the device is in self-refresh the block keeps clock enable low. An exit request raises it again, but only once the clock is reported stable and a minimum dwell has passed.

After exit, two independent timers gate what the scheduler may send. Reads wait for the longer read-exit interval. Every other command waits for the shorter non-read interval. Until then the block substitutes NOP on the bus, keeps termination off and reports readiness on two flags. A refresh is owed after every exit, so a new entry stays pending until the scheduler has issued at least one auto refresh and the read-exit interval has run out. All intervals are parameters counted in clock cycles.

Top module: `srx_self_refresh_seq`

## Requirements
- R1: After reset, mem_cke, ready_rd and ready_other are 1, mem_odt equals host_odt, and every host command other than self-refresh entry passes unchanged to mem_cmd. Command encoding: NOP=0, REF=1, SRE=2, RD=3, RDA=4, and 5 to 7 are other non-read commands.
- R2: An entry request seen while banks_idle is 0 or a refresh is owed is kept pending and not dropped. While it waits, CKE stays 1 and termination follows the host. Entry starts in the cycle after banks_idle is 1 with the request pending.
- R3: Once entry starts, exactly T_AOFD cycles with mem_odt=0, mem_cmd=NOP, mem_cke=1 and both ready flags 0 precede the self-refresh entry command.
- R4: The entry command (SRE) appears with mem_cke=0 in the same cycle. CKE then stays 0, with NOP and termination off, until an exit is accepted, and no exit is accepted earlier than T_IS cycles after the first self-refresh cycle.
- R5: An exit is accepted only in a cycle where clk_stable is 1. An exit request made while the clock is unstable is remembered. CKE rises in the cycle after acceptance.
- R6: Counting the first CKE-high cycle after exit as cycle 0, non-read commands are replaced by NOP and ready_other is 0 before cycle T_XSNR. They pass from cycle T_XSNR on.
- R7: RD and RDA are replaced by NOP and ready_rd is 0 before cycle T_XSRD. They pass from cycle T_XSRD on.
- R8: mem_odt stays 0 and mem_cke stays 1 throughout cycles 0 to T_XSRD-1 after exit.
- R9: After an exit, no new entry starts until the host has issued at least one REF that passed and the T_XSRD interval has expired. If that REF passes while an entry is pending, entry starts in the following cycle.
- R10: A host SRE code is always replaced by NOP. An exit request seen outside self-refresh and an entry request seen inside it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Request to place the device in self-refresh |
| exit_req | input | 1 | Request to leave self-refresh |
| banks_idle | input | 1 | All banks precharged and idle |
| clk_stable | input | 1 | Memory clock is stable |
| host_cmd | input | 3 | Command from the scheduler |
| host_odt | input | 1 | Termination request from the scheduler |
| mem_cmd | output | 3 | Command driven to the device |
| mem_cke | output | 1 | Clock-enable pin |
| mem_odt | output | 1 | Termination-enable pin |
| ready_rd | output | 1 | Reads may be issued |
| ready_other | output | 1 | Non-read commands may be issued |

## Verification
The two functions that can land in the same cycle are the passing of the owed refresh and a pending entry request. The refresh clears the owed flag at the edge that ends its cycle, so entry must begin exactly one cycle later. In one case the refresh is sent early, before the read-exit timer has run out, and entry must then wait for that timer. The bench provokes both by raising the entry request during the exit window and placing REF at a chosen cycle. It judges the result from the cycle in which termination drops and the cycle in which SRE appears. Constrained random commands in every window, together with random dwell and bank-busy lengths, are compared with expected values that bench functions compute from the cycle count since CKE rose.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_REF = 3'd1,
    CMD_SRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_RDA = 3'd4,
    CMD_WR  = 3'd5,
    CMD_ACT = 3'd6,
    CMD_PRE = 3'd7
  } srx_cmd_e;

  typedef enum logic [1:0] {
    ST_ACTIVE    = 2'd0,
    ST_ODT_DRAIN = 2'd1,
    ST_SELF      = 2'd2
  } srx_state_e;

  // bits needed to hold max_val
  function automatic int cnt_width(input int max_val);
    int w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic logic is_read(input logic [2:0] c);
    return (c == CMD_RD) || (c == CMD_RDA);
  endfunction

endpackage

// File: rtl/srx_down_counter.sv
module srx_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/srx_seq_fsm.sv
module srx_seq_fsm
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_req,
  input  logic       exit_req,
  input  logic       banks_idle,
  input  logic       clk_stable,
  input  logic       ref_issued,
  input  logic       aofd_zero,
  input  logic       dwell_zero,
  input  logic       xsrd_zero,
  output srx_state_e state,
  output logic       entry_start,
  output logic       sre_fire,
  output logic       exit_accept
);

  srx_state_e state_nx;
  logic       enter_pend;
  logic       exit_pend;
  logic       ref_owed;

  // entry needs idle banks, no owed refresh and the read-exit interval over
  assign entry_start = (state == ST_ACTIVE) && (enter_req || enter_pend) &&
                       banks_idle && !ref_owed && xsrd_zero;
  assign sre_fire    = (state == ST_ODT_DRAIN) && aofd_zero;
  assign exit_accept = (state == ST_SELF) && (exit_req || exit_pend) &&
                       clk_stable && dwell_zero;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_ACTIVE:    if (entry_start) state_nx = ST_ODT_DRAIN;
      ST_ODT_DRAIN: if (sre_fire)    state_nx = ST_SELF;
      ST_SELF:      if (exit_accept) state_nx = ST_ACTIVE;
      default:                       state_nx = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_ACTIVE;
      enter_pend <= 1'b0;
      exit_pend  <= 1'b0;
      ref_owed   <= 1'b0;
    end else begin
      state <= state_nx;

      if (sre_fire)                           enter_pend <= 1'b0;
      else if (enter_req && state != ST_SELF) enter_pend <= 1'b1;

      if (exit_accept)                        exit_pend <= 1'b0;
      else if (exit_req && state == ST_SELF)  exit_pend <= 1'b1;

      if (exit_accept)                        ref_owed <= 1'b1;
      else if (ref_issued)                    ref_owed <= 1'b0;
    end
  end

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_pend && state == ST_ACTIVE && !entry_start) |=> enter_pend); // R2

  AST_SELF_ON_SRE: assert property (@(posedge clk) disable iff (!rst_n)
    sre_fire |=> (state == ST_SELF)); // R4

endmodule

// File: rtl/srx_cmd_gate.sv
module srx_cmd_gate
  import srx_pkg::*;
(
  input  srx_state_e  state,
  input  logic        sre_fire,
  input  logic        xsrd_zero,
  input  logic        xsnr_zero,
  input  logic [2:0]  host_cmd,
  input  logic        host_odt,
  output logic [2:0]  mem_cmd,
  output logic        mem_cke,
  output logic        mem_odt,
  output logic        ready_rd,
  output logic        ready_other,
  output logic        ref_issued
);

  logic active;

  assign active      = (state == ST_ACTIVE);
  assign ready_rd    = active && xsrd_zero;
  assign ready_other = active && xsnr_zero;

  always_comb begin
    mem_cmd = CMD_NOP;
    if (sre_fire) begin
      mem_cmd = CMD_SRE;
    end else if (active) begin
      if (host_cmd == CMD_SRE)       mem_cmd = CMD_NOP;
      else if (is_read(host_cmd))    mem_cmd = ready_rd    ? host_cmd : CMD_NOP;
      else if (host_cmd != CMD_NOP)  mem_cmd = ready_other ? host_cmd : CMD_NOP;
    end
  end

  assign mem_cke    = !((state == ST_SELF) || sre_fire);
  assign mem_odt    = active && xsrd_zero && host_odt;
  assign ref_issued = (mem_cmd == CMD_REF);

endmodule

// File: rtl/srx_self_refresh_seq.sv
module srx_self_refresh_seq
  import srx_pkg::*;
#(
  parameter int T_XSNR = 50,
  parameter int T_XSRD = 200,
  parameter int T_AOFD = 3,
  parameter int T_IS   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_req,
  input  logic       exit_req,
  input  logic       banks_idle,
  input  logic       clk_stable,
  input  logic [2:0] host_cmd,
  input  logic       host_odt,
  output logic [2:0] mem_cmd,
  output logic       mem_cke,
  output logic       mem_odt,
  output logic       ready_rd,
  output logic       ready_other
);

  localparam int CMAX = max4(T_XSNR, T_XSRD, T_AOFD, T_IS);
  localparam int CW   = cnt_width(CMAX);
  localparam int NCNT = 4;
  // counter slots: 0 ODT lead, 1 self-refresh dwell, 2 read exit, 3 non-read exit
  localparam int LOADV [NCNT] = '{T_AOFD, T_IS, T_XSRD, T_XSNR};

  if (T_XSNR > T_XSRD) begin : g_param_check
    $error("T_XSNR must not exceed T_XSRD");
  end

  srx_state_e       state;
  logic             entry_start;
  logic             sre_fire;
  logic             exit_accept;
  logic             ref_issued;
  logic [NCNT-1:0]  cnt_load;
  logic [NCNT-1:0]  cnt_zero;

  assign cnt_load = {exit_accept, exit_accept, sre_fire, entry_start};

  for (genvar g = 0; g < NCNT; g++) begin : g_timer
    srx_down_counter #(.W(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load[g]),
      .load_val (CW'(LOADV[g])),
      .zero     (cnt_zero[g])
    );
  end

  srx_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_req   (enter_req),
    .exit_req    (exit_req),
    .banks_idle  (banks_idle),
    .clk_stable  (clk_stable),
    .ref_issued  (ref_issued),
    .aofd_zero   (cnt_zero[0]),
    .dwell_zero  (cnt_zero[1]),
    .xsrd_zero   (cnt_zero[2]),
    .state       (state),
    .entry_start (entry_start),
    .sre_fire    (sre_fire),
    .exit_accept (exit_accept)
  );

  srx_cmd_gate u_gate (
    .state       (state),
    .sre_fire    (sre_fire),
    .xsrd_zero   (cnt_zero[2]),
    .xsnr_zero   (cnt_zero[3]),
    .host_cmd    (host_cmd),
    .host_odt    (host_odt),
    .mem_cmd     (mem_cmd),
    .mem_cke     (mem_cke),
    .mem_odt     (mem_odt),
    .ready_rd    (ready_rd),
    .ready_other (ready_other),
    .ref_issued  (ref_issued)
  );

  // ---------------- pin-level checking state, independent of the FSM ----------------
  localparam int AW = cnt_width(T_XSRD);
  localparam int OW = cnt_width(T_AOFD);
  localparam logic [AW-1:0] XSRD_W = AW'(T_XSRD);
  localparam logic [AW-1:0] XSNR_W = AW'(T_XSNR);
  localparam logic [OW-1:0] AOFD_W = OW'(T_AOFD);

  logic [AW-1:0] exit_age;
  logic [OW-1:0] odt_low_run;
  logic          ref_since_exit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exit_age       <= XSRD_W;
      odt_low_run    <= '0;
      ref_since_exit <= 1'b1;
    end else begin
      if (!mem_cke)                exit_age <= '0;
      else if (exit_age != XSRD_W) exit_age <= exit_age + 1'b1;

      if (mem_odt)                    odt_low_run <= '0;
      else if (odt_low_run != AOFD_W) odt_low_run <= odt_low_run + 1'b1;

      if (!mem_cke)                ref_since_exit <= 1'b0;
      else if (mem_cmd == CMD_REF) ref_since_exit <= 1'b1;
    end
  end

  AST_ODT_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == CMD_SRE) |-> (odt_low_run >= AOFD_W)); // R3

  AST_CKE_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == CMD_SRE) |=> !mem_cke); // R4

  AST_CKE_RISE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cke) |-> $past(clk_stable)); // R5

  AST_OTHER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd != CMD_NOP && mem_cmd != CMD_SRE && !is_read(mem_cmd)) |-> (exit_age >= XSNR_W)); // R6

  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    is_read(mem_cmd) |-> (exit_age >= XSRD_W)); // R7

  AST_ODT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_odt |-> (exit_age >= XSRD_W)); // R8

  AST_CKE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cke && exit_age < XSRD_W) |=> mem_cke); // R8

  AST_REF_BEFORE_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == CMD_SRE) |-> ref_since_exit); // R9

endmodule

// File: tb/srx_self_refresh_seq_bench.sv
module srx_self_refresh_seq_bench;

  localparam int XSNR = 5;
  localparam int XSRD = 9;
  localparam int AOFD = 3;
  localparam int TIS  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enter_req = 1'b0;
  logic       exit_req = 1'b0;
  logic       banks_idle = 1'b1;
  logic       clk_stable = 1'b1;
  logic [2:0] host_cmd = 3'd0;
  logic       host_odt = 1'b1;
  logic [2:0] mem_cmd;
  logic       mem_cke;
  logic       mem_odt;
  logic       ready_rd;
  logic       ready_other;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  srx_self_refresh_seq #(.T_XSNR(XSNR), .T_XSRD(XSRD), .T_AOFD(AOFD), .T_IS(TIS))
  u_srx_self_refresh_seq (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
    .banks_idle(banks_idle), .clk_stable(clk_stable), .host_cmd(host_cmd),
    .host_odt(host_odt), .mem_cmd(mem_cmd), .mem_cke(mem_cke), .mem_odt(mem_odt),
    .ready_rd(ready_rd), .ready_other(ready_other)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // expected bus command k cycles after CKE rose (large k means steady state)
  function automatic int exp_cmd(input int c, input int k);
    if (c == 0 || c == 2) return 0;
    if (c == 3 || c == 4) return (k >= XSRD) ? c : 0;
    return (k >= XSNR) ? c : 0;
  endfunction

  function automatic logic [2:0] pick_busy_cmd();
    int r;
    r = $urandom % 6;
    return (r == 0) ? 3'd0 : 3'(r + 2);
  endfunction

  task automatic request_entry(input int b);
    cyc();
    host_cmd = 3'd0; host_odt = 1'b1;
    enter_req = 1'b1; banks_idle = (b == 0);
    #2;
    chk(mem_odt == 1'b1, "R2", "odt on request cycle", mem_odt, 1);
    for (int i = 0; i < b; i++) begin
      cyc();
      enter_req = 1'b0; banks_idle = (i == b - 1);
      #2;
      chk(mem_odt == 1'b1 && mem_cke == 1'b1, "R2", "odt/cke while pending", {mem_odt, mem_cke}, 3);
      chk(ready_other == 1'b1, "R2", "ready_other while pending", ready_other, 1);
    end
  endtask

  task automatic check_entry_from_next();
    for (int i = 0; i < AOFD; i++) begin
      cyc();
      enter_req = 1'b0; banks_idle = 1'b1; host_odt = 1'b1;
      host_cmd = 3'(3 + ($urandom % 5));
      #2;
      chk(mem_odt == 1'b0, "R3", "odt in lead", mem_odt, 0);
      chk(mem_cmd == 3'd0 && mem_cke == 1'b1, "R3", "cmd/cke in lead", {mem_cmd, mem_cke}, 1);
      chk(ready_rd == 1'b0 && ready_other == 1'b0, "R3", "ready in lead", {ready_rd, ready_other}, 0);
    end
    cyc();
    host_cmd = 3'd0;
    #2;
    chk(mem_cmd == 3'd2, "R4", "SRE command", mem_cmd, 2);
    chk(mem_cke == 1'b0, "R4", "cke with SRE", mem_cke, 0);
  endtask

  task automatic dwell_and_exit(input int w);
    int acc;
    acc = (w > TIS) ? w : TIS;
    for (int s = 0; s <= acc; s++) begin
      cyc();
      exit_req = (s == w); host_cmd = pick_busy_cmd(); host_odt = 1'b1;
      #2;
      chk(mem_cke == 1'b0, "R4", "cke during dwell", mem_cke, 0);
      chk(mem_cmd == 3'd0 && mem_odt == 1'b0, "R4", "cmd/odt in self", {mem_cmd, mem_odt}, 0);
    end
  endtask

  task automatic exit_window(input int len, input int enter_at, input int ref_at);
    logic [2:0] c;
    int e;
    for (int k = 0; k < len; k++) begin
      cyc();
      exit_req = 1'b0;
      enter_req = (k == enter_at);
      c = pick_busy_cmd();
      if (k == ref_at) c = 3'd1;
      host_cmd = c; host_odt = 1'b1;
      #2;
      e = (c == 3'd1) ? ((k >= XSNR) ? 1 : 0) : exp_cmd(c, k);
      chk(mem_cke == 1'b1, "R8", "cke after exit", mem_cke, 1);
      chk(mem_odt == (k >= XSRD), "R8", "odt after exit", mem_odt, int'(k >= XSRD));
      chk(ready_rd == (k >= XSRD), "R7", "ready_rd", ready_rd, int'(k >= XSRD));
      chk(ready_other == (k >= XSNR), "R6", "ready_other", ready_other, int'(k >= XSNR));
      chk(int'(mem_cmd) == e, (c == 3 || c == 4) ? "R7" : "R6", "gated cmd", mem_cmd, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] c;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(mem_cke == 1'b1, "R1", "cke after reset", mem_cke, 1);
    chk(ready_rd == 1'b1 && ready_other == 1'b1, "R1", "ready after reset", {ready_rd, ready_other}, 3);
    chk(mem_odt == 1'b1, "R1", "odt follows host", mem_odt, 1);

    // steady state pass-through, random commands and termination
    for (int i = 0; i < 40; i++) begin
      cyc();
      c = 3'($urandom % 8);
      host_cmd = c; host_odt = 1'($urandom % 2);
      #2;
      chk(int'(mem_cmd) == exp_cmd(c, 1000), (c == 3'd2) ? "R10" : "R1", "pass-through", mem_cmd, exp_cmd(c, 1000));
      chk(mem_odt == host_odt, "R1", "odt pass", mem_odt, host_odt);
    end

    // exit request outside self-refresh must be forgotten
    cyc();
    host_cmd = 3'd0; host_odt = 1'b1; exit_req = 1'b1;
    #2;
    chk(mem_cke == 1'b1, "R10", "cke on stray exit", mem_cke, 1);
    cyc();
    exit_req = 1'b0;

    // entry held while banks busy
    request_entry(6);
    check_entry_from_next();

    // entry request inside self-refresh ignored, stray exit not remembered
    for (int i = 0; i < 6; i++) begin
      cyc();
      host_cmd = pick_busy_cmd(); enter_req = (i == 1);
      #2;
      chk(mem_cke == 1'b0, "R10", "cke stays low", mem_cke, 0);
      chk(mem_cmd == 3'd0, "R4", "NOP in self", mem_cmd, 0);
    end
    enter_req = 1'b0;

    // exit with the clock not yet stable
    cyc();
    clk_stable = 1'b0; exit_req = 1'b1;
    #2;
    chk(mem_cke == 1'b0, "R5", "cke, clock unstable", mem_cke, 0);
    cyc();
    exit_req = 1'b0;
    for (int i = 0; i < 3; i++) begin
      cyc();
      #2;
      chk(mem_cke == 1'b0, "R5", "cke waits for clock", mem_cke, 0);
    end
    cyc();
    clk_stable = 1'b1;
    #2;
    chk(mem_cke == 1'b0, "R5", "cke in accept cycle", mem_cke, 0);
    exit_window(XSRD + 4, 1, -1);

    // pending entry but no refresh yet
    for (int i = 0; i < 8; i++) begin
      cyc();
      host_cmd = 3'd0; host_odt = 1'b1;
      #2;
      chk(mem_cke == 1'b1 && mem_odt == 1'b1, "R9", "no entry before REF", {mem_cke, mem_odt}, 3);
    end
    // REF passes while entry pending: entry starts next cycle
    cyc();
    host_cmd = 3'd1;
    #2;
    chk(mem_cmd == 3'd1, "R9", "REF passes", mem_cmd, 1);
    chk(mem_odt == 1'b1, "R9", "odt in REF cycle", mem_odt, 1);
    cyc();
    host_cmd = 3'd0;
    #2;
    chk(mem_odt == 1'b1, "R9", "odt cycle after REF", mem_odt, 1);
    check_entry_from_next();

    // early REF during the window: entry waits for the read timer
    dwell_and_exit(0);
    exit_window(XSRD + 1, 1, XSNR);
    check_entry_from_next();

    // random dwell and bank-busy lengths
    for (int it = 0; it < 3; it++) begin
      dwell_and_exit(int'($urandom % 5));
      exit_window(XSRD + 1, -1, -1);
      cyc();
      host_cmd = 3'd1;
      #2;
      chk(mem_cmd == 3'd1, "R9", "REF before entry", mem_cmd, 1);
      request_entry(int'($urandom % 4));
      check_entry_from_next();
    end

    dwell_and_exit(1);
    exit_window(XSRD + 2, -1, -1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule